// File: doc/BRIEF.md
# Four-Way Pairwise-Order LRU Victim Selector with Way Locking

This block does the replacement bookkeeping for one set of a four-way set-associative cache. Each set keeps six bits of age state. Each bit records, for one pair of ways, which of the two was used more recently. Together the six bits give a full least-recently-used order. The block does not hold the per-set state. The cache reads the six bits of the addressed set, presents them to the block with the request, and writes the returned state back.

On a hit the caller names the accessed way. The block marks that way as newer than the other three and returns the new six bits. On a miss the block picks the victim: the eligible way that is older than every other eligible way. Ways 2 and 3 can each be locked. A locked way is never chosen. In the same cycle the block updates the state as if the victim had just been filled.

Results are registered. They appear one clock after a request and hold until the next request.

Top module: `lru6_sel`

## Requirements
- R1: While reset is asserted, and after it is released, `rsp_valid`, `state_out` and `victim_out` read 0 until the first request registers.
- R2: One cycle after a hit request (`req_valid`=1, `req_miss`=0) to way w, `state_out` equals `state_in` with w marked newest. The three pair bits that involve w are changed and the other three are copied. Bit layout: b0=(0,1), b1=(0,2), b2=(0,3), b3=(1,2), b4=(1,3), b5=(2,3). A bit set to 1 means the lower-numbered way of its pair is the more recent one.
- R3: With no lock set, `victim_out` is the way that is older than all three other ways under the R2 encoding.
- R4: When `lock_w2` is 1, `victim_out` is never 2. When `lock_w3` is 1, `victim_out` is never 3. The victim is the oldest of the remaining ways.
- R5: When both locks are set, the victim is 0 if b0=0 and 1 if b0=1.
- R6: On a miss request, the state update treats the selected victim as the accessed way, and `req_way` has no effect.
- R7: If no eligible way is older than all other eligible ways (an inconsistent state), the victim is the lowest-numbered qualifying way, or way 0 if none qualifies.
- R8: `rsp_valid` is `req_valid` delayed by one cycle. While `req_valid` is 0, `state_out` and `victim_out` hold their values.
- R9: The all-zero state with no locks selects way 0 as the victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_miss | input | 1 | 1 = miss (fill the victim), 0 = hit to `req_way` |
| req_way | input | 2 | Accessed way on a hit |
| state_in | input | 6 | Current pairwise age bits of the set |
| lock_w2 | input | 1 | Way 2 is locked |
| lock_w3 | input | 1 | Way 3 is locked |
| rsp_valid | output | 1 | Registered result is from the previous cycle's request |
| state_out | output | 6 | Updated age bits to write back |
| victim_out | output | 2 | Selected victim way |

## Verification
On a miss, victim decode and state update fall in the same cycle, and the update's accessed way is the decoder's own output. The bench issues misses on states where the oldest way is locked or unlocked, and where the age bits are inconsistent. In each case it checks two things: that `victim_out` matches an independent age-order model, and that `state_out` marks exactly that victim as newest, even with a misleading `req_way` applied. The checker also ties each registered victim to the newest-way pattern in the returned state.

// File: rtl/lru6_pkg.sv
package lru6_pkg;
  localparam int NWAYS  = 4;
  localparam int WAYW   = $clog2(NWAYS);
  localparam int NPAIRS = NWAYS * (NWAYS - 1) / 2;

  typedef logic [WAYW-1:0]   way_t;
  typedef logic [NPAIRS-1:0] age_t;

  // Index of the bit that orders ways a < b; bit = 1 means a is more recent.
  function automatic int pair_idx(input int a, input int b);
    return a * (2 * NWAYS - a - 1) / 2 + (b - a - 1);
  endfunction
endpackage

// File: rtl/lru6_update.sv
module lru6_update
  import lru6_pkg::*;
(
  input  age_t cur,
  input  way_t way,
  output age_t nxt
);
  for (genvar a = 0; a < NWAYS; a++) begin : g_lo
    for (genvar b = a + 1; b < NWAYS; b++) begin : g_hi
      localparam int K = pair_idx(a, b);
      always_comb begin
        if (way == way_t'(a))      nxt[K] = 1'b1;
        else if (way == way_t'(b)) nxt[K] = 1'b0;
        else                       nxt[K] = cur[K];
      end
    end
  end
endmodule

// File: rtl/lru6_victim.sv
module lru6_victim
  import lru6_pkg::*;
#(
  parameter int FIRST_LOCKABLE = 2
)(
  input  age_t                    age,
  input  logic [NWAYS-1:0]        lock,
  output way_t                    victim
);
  logic [NWAYS-1:0] elig;
  logic [NWAYS-1:0] oldest;

  for (genvar v = 0; v < NWAYS; v++) begin : g_way
    if (v < FIRST_LOCKABLE) begin : g_fixed
      assign elig[v] = 1'b1;
    end else begin : g_lockable
      assign elig[v] = ~lock[v];
    end

    always_comb begin
      oldest[v] = elig[v];
      for (int u = 0; u < NWAYS; u++) begin
        if (u != v && elig[u]) begin
          if (u > v) begin
            if (age[pair_idx(v, u)]) oldest[v] = 1'b0;
          end else begin
            if (!age[pair_idx(u, v)]) oldest[v] = 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int v = NWAYS - 1; v >= 0; v--) begin
      if (oldest[v]) victim = way_t'(v);
    end
  end
endmodule

// File: rtl/lru6_sel.sv
module lru6_sel
  import lru6_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_miss,
  input  logic [1:0] req_way,
  input  logic [5:0] state_in,
  input  logic       lock_w2,
  input  logic       lock_w3,
  output logic       rsp_valid,
  output logic [5:0] state_out,
  output logic [1:0] victim_out
);
  logic       rst_meta, rst_q;
  logic [NWAYS-1:0] lock_vec;
  way_t victim_c, upd_way;
  age_t state_c;
  age_t state_d;
  way_t victim_d;
  logic valid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  assign lock_vec = {lock_w3, lock_w2, 2'b00};

  lru6_victim u_victim (
    .age    (state_in),
    .lock   (lock_vec),
    .victim (victim_c)
  );

  assign upd_way = req_miss ? victim_c : req_way;

  lru6_update u_update (
    .cur (state_in),
    .way (upd_way),
    .nxt (state_c)
  );

  always_comb begin
    valid_d  = req_valid;
    state_d  = state_out;
    victim_d = victim_out;
    if (req_valid) begin
      state_d  = state_c;
      victim_d = victim_c;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rsp_valid  <= 1'b0;
      state_out  <= '0;
      victim_out <= '0;
    end else begin
      rsp_valid  <= valid_d;
      state_out  <= state_d;
      victim_out <= victim_d;
    end
  end
endmodule

// File: rtl/lru6_sel_chk.sv
module lru6_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_q,
  input logic       req_valid,
  input logic       req_miss,
  input logic [1:0] req_way,
  input logic       lock_w2,
  input logic       lock_w3,
  input logic       rsp_valid,
  input logic [5:0] state_out,
  input logic [1:0] victim_out
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r1: assert (!rsp_valid && state_out == 6'd0 && victim_out == 2'd0)
        else $error("p_reset_r1");
    end
  end

  p_hit_w0_r2: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid && !req_miss && req_way == 2'd0 |=> state_out[2:0] == 3'b111);

  p_hit_w3_r2: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid && !req_miss && req_way == 2'd3 |=> state_out[2] == 1'b0 && state_out[5:4] == 2'b00);

  p_lock2_r4: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid && lock_w2 |=> victim_out != 2'd2);

  p_lock3_r4: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid && lock_w3 |=> victim_out != 2'd3);

  p_both_locked_r5: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid && lock_w2 && lock_w3 |=> !victim_out[1]);

  p_miss_fill_w0_r6: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid && req_miss |=> victim_out != 2'd0 || state_out[2:0] == 3'b111);

  p_miss_fill_w1_r6: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid && req_miss |=> victim_out != 2'd1 || state_out[4:3] == 2'b11 && !state_out[0]);

  p_valid_delay_r8: assert property (@(posedge clk) disable iff (!rst_q)
    1'b1 |=> rsp_valid == $past(req_valid));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !req_valid |=> $stable(state_out) && $stable(victim_out));
endmodule

bind lru6_sel lru6_sel_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_q      (rst_q),
  .req_valid  (req_valid),
  .req_miss   (req_miss),
  .req_way    (req_way),
  .lock_w2    (lock_w2),
  .lock_w3    (lock_w3),
  .rsp_valid  (rsp_valid),
  .state_out  (state_out),
  .victim_out (victim_out)
);

// File: tb/tb_lru6_sel.sv
module tb_lru6_sel;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_miss = 1'b0, lock_w2 = 1'b0, lock_w3 = 1'b0;
  logic [1:0] req_way = 2'd0;
  logic [5:0] state_in = 6'd0;
  logic rsp_valid;
  logic [5:0] state_out;
  logic [1:0] victim_out;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lru6_sel dut (.*);

  function automatic int bit_of(input int a, input int b);
    int lo, hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    case ({lo[1:0], hi[1:0]})
      4'b0001: return 0;
      4'b0010: return 1;
      4'b0011: return 2;
      4'b0110: return 3;
      4'b0111: return 4;
      default: return 5;
    endcase
  endfunction

  // 1 when way a was used less recently than way b
  function automatic bit is_older(input logic [5:0] s, input int a, input int b);
    bit lo_newer;
    lo_newer = s[bit_of(a, b)];
    return (a < b) ? !lo_newer : lo_newer;
  endfunction

  function automatic logic [5:0] m_touch(input logic [5:0] s, input int w);
    logic [5:0] r;
    r = s;
    for (int o = 0; o < 4; o++)
      if (o != w) r[bit_of(w, o)] = (w < o);
    return r;
  endfunction

  function automatic logic [1:0] m_victim(input logic [5:0] s, input bit l2, input bit l3);
    bit ok[4];
    ok[0] = 1; ok[1] = 1; ok[2] = !l2; ok[3] = !l3;
    for (int v = 0; v < 4; v++) begin
      bit all;
      all = ok[v];
      for (int u = 0; u < 4; u++)
        if (u != v && ok[u] && !is_older(s, v, u)) all = 0;
      if (all) return 2'(v);
    end
    return 2'd0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input bit miss, input logic [1:0] w, input logic [5:0] s,
                       input bit l2, input bit l3);
    @(negedge clk);
    req_valid = 1; req_miss = miss; req_way = w; state_in = s; lock_w2 = l2; lock_w3 = l3;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid in reset", rsp_valid, 0);
    chk("R1 state_out in reset", state_out, 0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 state_out after release", state_out, 0);
    chk("R1 victim_out after release", victim_out, 0);
  endtask

  task automatic t_zero_victim;
    issue(0, 2'd3, 6'h00, 0, 0);
    chk("R9 victim of zero state", victim_out, 0);
    chk("R8 rsp_valid after request", rsp_valid, 1);
  endtask

  task automatic t_hits;
    logic [5:0] s;
    s = 6'h00;
    for (int k = 0; k < 8; k++) begin
      int w;
      w = (k * 3 + 1) % 4;
      issue(0, 2'(w), s, 0, 0);
      chk("R2 hit update", state_out, m_touch(s, w));
      chk("R3 victim no locks", victim_out, m_victim(s, 0, 0));
      s = state_out;
    end
    issue(0, 2'd0, 6'h00, 0, 0);
    chk("R2 hit way0 from zero", state_out, 6'h07);
  endtask

  task automatic t_locks;
    issue(0, 2'd1, 6'h0A, 0, 0);
    chk("R3 way2 oldest", victim_out, 2);
    issue(0, 2'd1, 6'h0A, 1, 0);
    chk("R4 way2 locked", victim_out, 0);
    issue(0, 2'd1, 6'h0A, 0, 1);
    chk("R4 way3 locked keeps way2", victim_out, 2);
    issue(0, 2'd1, 6'h34, 0, 0);
    chk("R3 way3 oldest", victim_out, 3);
    issue(0, 2'd1, 6'h34, 0, 1);
    chk("R4 way3 locked", victim_out, 0);
  endtask

  task automatic t_both_locked;
    issue(0, 2'd2, 6'h07, 1, 1);
    chk("R5 both locked b0=1", victim_out, 1);
    issue(0, 2'd2, 6'h34, 1, 1);
    chk("R5 both locked b0=0", victim_out, 0);
  endtask

  task automatic t_miss;
    issue(1, 2'd3, 6'h0A, 0, 0);
    chk("R6 miss victim", victim_out, 2);
    chk("R6 miss fills victim", state_out, m_touch(6'h0A, 2));
    issue(1, 2'd2, 6'h0A, 1, 0);
    chk("R6 miss locked victim", victim_out, 0);
    chk("R6 miss fill ignores req_way", state_out, m_touch(6'h0A, 0));
    issue(1, 2'd0, 6'h07, 1, 1);
    chk("R6 miss both locked fill", state_out, m_touch(6'h07, 1));
  endtask

  task automatic t_inconsistent;
    issue(1, 2'd3, 6'h09, 0, 0);
    chk("R7 cyclic state victim", victim_out, 0);
    chk("R7 cyclic state fill", state_out, m_touch(6'h09, 0));
  endtask

  task automatic t_hold;
    issue(0, 2'd1, 6'h0A, 0, 0);
    @(negedge clk);
    state_in = 6'h3F; req_way = 2'd3; lock_w2 = 1;
    @(negedge clk);
    chk("R8 rsp_valid drops", rsp_valid, 0);
    chk("R8 state held", state_out, m_touch(6'h0A, 1));
    chk("R8 victim held", victim_out, 2);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_zero_victim();
        t_hits();
        t_locks();
        t_both_locked();
        t_miss();
        t_inconsistent();
        t_hold();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule